// File: doc/BRIEF.md
# Scanline Width and Spacing Rule Checker

This block sits at the end of a scanline layout-checking pipeline. It receives a stream of points that an upstream stage has already classified. Each point is either a scanline marker that carries the X position of the next group, a true point of the merged region, or a virtual point that extends an edge. For each layer of a small group, the block keeps the latest stored Y value, orientation and starting-endpoint flag. It subtracts these stored values from the Y of every incoming point. Each difference is compared against programmed minimum widths and spacings.

A check runs only when the orientation of the stored point and the orientation of the current point form a width pattern or a spacing pattern. Duplicate reports are suppressed unless a starting-endpoint condition holds. Every violation becomes an error record on a per-layer output lane.

The block also emits virtual points. These extend certain true ending endpoints by the largest rule that applies to their layer, so that violations which only meet at a corner are still seen by a later scanline. Thresholds are loaded through a small write port before a run.

Top module: `drc_scan_checker`

## Requirements
- R1: A point with `pt_marker=1` sets the scanline X to its `pt_y` and invalidates the stored point of every layer. It produces neither an error nor a virtual point, and no check fires against an invalidated layer until that layer stores again.
- R2: Only a point with `pt_true=1` and `pt_virtual=0` overwrites the stored Y, orientation and starting flag of its layer. A virtual point is checked but stores nothing. A point with `pt_true=0` and `pt_virtual=0` is ignored entirely.
- R3: A same-layer width check (rule code 1) runs when the stored point is forward (orientation 0) and the current point is backward (orientation 1).
- R4: A same-layer spacing check (rule code 2) runs when the stored point is backward and the current point is forward.
- R5: A cross-layer spacing check (rule code 3) runs when another layer's stored point is backward and the current point is forward. It uses the threshold of that unordered layer pair.
- R6: A check reports only when the current Y minus the stored Y is strictly greater than zero and strictly less than the threshold.
- R7: A check reports only if the current point is a true starting endpoint (`pt_start=1`, `pt_true_end=1`, not virtual), or if the stored point was a starting endpoint.
- R8: A virtual point is emitted for a non-virtual true ending endpoint (`pt_end=1`, `pt_true_end=1`) in two cases: it is forward with `pt_right_in=0`, or it is backward with `pt_right_in=1`.
- R9: An emitted virtual point copies Y, layer and orientation. Its X extension equals the largest width, spacing or cross threshold that involves its layer.
- R10: Results appear one clock after the point. Lane k of `err_valid` flags a violation against stored layer k. The record carries the scanline X, the current Y, the current layer, and the 2-bit rule code and stored Y for each lane.
- R11: Threshold writes use `cfg_kind` 0 for width of `cfg_la`, 1 for spacing of `cfg_la`, and 2 for the cross pair (`cfg_la`,`cfg_lb`), which is stored symmetrically. A write applies to points presented in later cycles.
- R12: After reset all thresholds are zero, the scanline X is zero, all layers are invalid and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_kind | input | 2 | 0 width, 1 same-layer spacing, 2 cross spacing |
| cfg_la | input | LW | First layer of the write |
| cfg_lb | input | LW | Second layer (cross writes only) |
| cfg_val | input | TW | Threshold in grid units |
| pt_valid | input | 1 | Point present this cycle |
| pt_marker | input | 1 | Point is a scanline marker; `pt_y` holds X |
| pt_y | input | YW | Y coordinate (or X for a marker) |
| pt_layer | input | LW | Layer of the point |
| pt_orient | input | 1 | 0 forward, 1 backward |
| pt_start | input | 1 | Starting endpoint |
| pt_end | input | 1 | Ending endpoint |
| pt_true | input | 1 | On the merged region boundary |
| pt_true_end | input | 1 | Endpoint of the merged region |
| pt_virtual | input | 1 | Virtual point |
| pt_right_in | input | 1 | Region is inside to the right of the point |
| err_valid | output | NL | Violation per stored-layer lane |
| err_x | output | YW | Scanline X of the records |
| err_y | output | YW | Current point Y |
| err_layer | output | LW | Current point layer |
| err_rule | output | 2*NL | Rule code per lane |
| err_yref | output | YW*NL | Stored Y per lane |
| vp_valid | output | 1 | Virtual point emitted |
| vp_y | output | YW | Virtual point Y |
| vp_layer | output | LW | Virtual point layer |
| vp_orient | output | 1 | Virtual point orientation |
| vp_xext | output | TW | Virtual point X extension |

## Verification
Every record and every virtual point is registered once. It is due on the clock edge that samples the point and stays there for one cycle. The bench drives each point after a falling edge and compares all outputs on the next falling edge against a behavioural model. The model works out the record from the state it held before that point.

A threshold write lands on the same edge it is sampled on, so the bench expects it to affect the very next point. Each stored-layer update is likewise visible to the point that follows immediately, which the back-to-back point sequences exercise.

// File: rtl/drc_pkg.sv
package drc_pkg;

  typedef enum logic [1:0] {
    RULE_NONE  = 2'd0,
    RULE_WIDTH = 2'd1,
    RULE_SPACE = 2'd2,
    RULE_CROSS = 2'd3
  } rule_e;

  typedef enum logic [1:0] {
    CFG_WIDTH = 2'd0,
    CFG_SPACE = 2'd1,
    CFG_CROSS = 2'd2
  } cfg_kind_e;

  // Orientation pattern that selects which check applies.
  function automatic rule_e pick_rule(input logic same, input logic o_ref,
                                      input logic o_cur);
    rule_e r;
    r = RULE_NONE;
    if (same) begin
      if (!o_ref && o_cur)      r = RULE_WIDTH;
      else if (o_ref && !o_cur) r = RULE_SPACE;
    end else if (o_ref && !o_cur) begin
      r = RULE_CROSS;
    end
    return r;
  endfunction

  // Ending endpoints that must be extended into virtual edges.
  function automatic logic needs_virtual(input logic orient, input logic right_in);
    return orient ? right_in : !right_in;
  endfunction

endpackage

// File: rtl/drc_thresh.sv
module drc_thresh
  import drc_pkg::*;
#(
  parameter int NL = 4,
  parameter int TW = 6,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    kind,
  input  logic [LW-1:0] la,
  input  logic [LW-1:0] lb,
  input  logic [TW-1:0] val,
  output logic [TW-1:0] thr_w   [NL],
  output logic [TW-1:0] thr_s   [NL],
  output logic [TW-1:0] thr_x   [NL][NL],
  output logic [TW-1:0] thr_max [NL]
);

  for (genvar i = 0; i < NL; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        thr_w[i] <= '0;
        thr_s[i] <= '0;
      end else if (we && la == LW'(i)) begin
        if (kind == 2'(CFG_WIDTH)) thr_w[i] <= val;
        if (kind == 2'(CFG_SPACE)) thr_s[i] <= val;
      end
    end

    for (genvar j = 0; j < NL; j++) begin : g_col
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          thr_x[i][j] <= '0;
        end else if (we && kind == 2'(CFG_CROSS) &&
                     ((la == LW'(i) && lb == LW'(j)) ||
                      (la == LW'(j) && lb == LW'(i)))) begin
          thr_x[i][j] <= val;
        end
      end
    end

    // Largest rule touching layer i: sets the reach of its virtual edges.
    always_comb begin
      thr_max[i] = (thr_w[i] > thr_s[i]) ? thr_w[i] : thr_s[i];
      for (int j = 0; j < NL; j++) begin
        if (j != i && thr_x[i][j] > thr_max[i]) thr_max[i] = thr_x[i][j];
      end
    end
  end

endmodule

// File: rtl/drc_lane.sv
module drc_lane
  import drc_pkg::*;
#(
  parameter int YW  = 18,
  parameter int TW  = 6,
  parameter int LW  = 2,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic          chk,
  input  logic [YW-1:0] cur_y,
  input  logic [LW-1:0] cur_layer,
  input  logic          cur_o,
  input  logic          cur_start,
  input  logic          cur_tstart,
  input  logic [TW-1:0] thr_w,
  input  logic [TW-1:0] thr_s,
  input  logic [TW-1:0] thr_x,
  output logic          hit,
  output logic [1:0]    rule,
  output logic [YW-1:0] yref
);

  localparam int PADW = YW - TW;

  logic          v_q, o_q, s_q;
  logic [YW-1:0] y_q;

  // True when 0 < a - b < thr.
  function automatic logic in_window(input logic [YW-1:0] a, input logic [YW-1:0] b,
                                     input logic [TW-1:0] thr);
    logic [YW:0] d;
    d = {1'b0, a} - {1'b0, b};
    return !d[YW] && (d[YW-1:0] != '0) && (d[YW-1:0] < {{PADW{1'b0}}, thr});
  endfunction

  rule_e         r;
  logic [TW-1:0] thr;
  logic          same;

  assign same = (cur_layer == LW'(IDX));

  always_comb begin
    r = v_q ? pick_rule(same, o_q, cur_o) : RULE_NONE;
    unique case (r)
      RULE_WIDTH: thr = thr_w;
      RULE_SPACE: thr = thr_s;
      RULE_CROSS: thr = thr_x;
      default:    thr = '0;
    endcase
  end

  // Flagging: current true start, or stored point was a start.
  assign hit  = chk && (r != RULE_NONE) && in_window(cur_y, y_q, thr) &&
                (cur_tstart || s_q);
  assign rule = r;
  assign yref = y_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      o_q <= 1'b0;
      s_q <= 1'b0;
      y_q <= '0;
    end else if (clr) begin
      v_q <= 1'b0;
    end else if (upd) begin
      v_q <= 1'b1;
      o_q <= cur_o;
      s_q <= cur_start;
      y_q <= cur_y;
    end
  end

endmodule

// File: rtl/drc_vgen.sv
module drc_vgen
  import drc_pkg::*;
#(
  parameter int YW = 18,
  parameter int TW = 6,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          in_virtual,
  input  logic          in_true_end,
  input  logic          in_end,
  input  logic          in_orient,
  input  logic          in_right_in,
  input  logic [YW-1:0] in_y,
  input  logic [LW-1:0] in_layer,
  input  logic [TW-1:0] in_xext,
  output logic          fire,
  output logic          vp_valid,
  output logic [YW-1:0] vp_y,
  output logic [LW-1:0] vp_layer,
  output logic          vp_orient,
  output logic [TW-1:0] vp_xext
);

  assign fire = take && !in_virtual && in_true_end && in_end &&
                needs_virtual(in_orient, in_right_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vp_valid  <= 1'b0;
      vp_y      <= '0;
      vp_layer  <= '0;
      vp_orient <= 1'b0;
      vp_xext   <= '0;
    end else begin
      vp_valid <= fire;
      if (fire) begin
        vp_y      <= in_y;
        vp_layer  <= in_layer;
        vp_orient <= in_orient;
        vp_xext   <= in_xext;
      end
    end
  end

endmodule

// File: rtl/drc_scan_checker.sv
module drc_scan_checker
  import drc_pkg::*;
#(
  parameter int NL = 4,
  parameter int YW = 18,
  parameter int TW = 6,
  parameter int LW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_kind,
  input  logic [LW-1:0]    cfg_la,
  input  logic [LW-1:0]    cfg_lb,
  input  logic [TW-1:0]    cfg_val,
  input  logic             pt_valid,
  input  logic             pt_marker,
  input  logic [YW-1:0]    pt_y,
  input  logic [LW-1:0]    pt_layer,
  input  logic             pt_orient,
  input  logic             pt_start,
  input  logic             pt_end,
  input  logic             pt_true,
  input  logic             pt_true_end,
  input  logic             pt_virtual,
  input  logic             pt_right_in,
  output logic [NL-1:0]    err_valid,
  output logic [YW-1:0]    err_x,
  output logic [YW-1:0]    err_y,
  output logic [LW-1:0]    err_layer,
  output logic [2*NL-1:0]  err_rule,
  output logic [YW*NL-1:0] err_yref,
  output logic             vp_valid,
  output logic [YW-1:0]    vp_y,
  output logic [LW-1:0]    vp_layer,
  output logic             vp_orient,
  output logic [TW-1:0]    vp_xext
);

  // Named internal events (observed by the bound checker).
  logic          ev_marker;
  logic          ev_take;
  logic          ev_store;
  logic          ev_tstart;
  logic          ev_vfire;
  logic [NL-1:0] ev_hit;

  assign ev_marker = pt_valid && pt_marker;
  assign ev_take   = pt_valid && !pt_marker && (pt_true || pt_virtual);
  assign ev_store  = ev_take && pt_true && !pt_virtual;
  assign ev_tstart = ev_take && !pt_virtual && pt_start && pt_true_end;

  logic [TW-1:0] thr_w   [NL];
  logic [TW-1:0] thr_s   [NL];
  logic [TW-1:0] thr_x   [NL][NL];
  logic [TW-1:0] thr_max [NL];

  drc_thresh #(.NL(NL), .TW(TW), .LW(LW)) u_thresh (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .kind    (cfg_kind),
    .la      (cfg_la),
    .lb      (cfg_lb),
    .val     (cfg_val),
    .thr_w   (thr_w),
    .thr_s   (thr_s),
    .thr_x   (thr_x),
    .thr_max (thr_max)
  );

  logic [1:0]    lane_rule [NL];
  logic [YW-1:0] lane_yref [NL];

  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic [TW-1:0] tx;
    assign tx = thr_x[k][pt_layer];

    drc_lane #(.YW(YW), .TW(TW), .LW(LW), .IDX(k)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (ev_marker),
      .upd        (ev_store && pt_layer == LW'(k)),
      .chk        (ev_take),
      .cur_y      (pt_y),
      .cur_layer  (pt_layer),
      .cur_o      (pt_orient),
      .cur_start  (pt_start),
      .cur_tstart (ev_tstart),
      .thr_w      (thr_w[k]),
      .thr_s      (thr_s[k]),
      .thr_x      (tx),
      .hit        (ev_hit[k]),
      .rule       (lane_rule[k]),
      .yref       (lane_yref[k])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        err_rule[2*k +: 2]  <= 2'(RULE_NONE);
        err_yref[YW*k +: YW] <= '0;
      end else begin
        err_rule[2*k +: 2]  <= ev_hit[k] ? lane_rule[k] : 2'(RULE_NONE);
        err_yref[YW*k +: YW] <= ev_hit[k] ? lane_yref[k] : '0;
      end
    end
  end

  logic [YW-1:0] cur_x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_x     <= '0;
      err_valid <= '0;
      err_x     <= '0;
      err_y     <= '0;
      err_layer <= '0;
    end else begin
      if (ev_marker) cur_x <= pt_y;
      err_valid <= ev_hit;
      if (|ev_hit) begin
        err_x     <= cur_x;
        err_y     <= pt_y;
        err_layer <= pt_layer;
      end
    end
  end

  drc_vgen #(.YW(YW), .TW(TW), .LW(LW)) u_vgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (ev_take),
    .in_virtual  (pt_virtual),
    .in_true_end (pt_true_end),
    .in_end      (pt_end),
    .in_orient   (pt_orient),
    .in_right_in (pt_right_in),
    .in_y        (pt_y),
    .in_layer    (pt_layer),
    .in_xext     (thr_max[pt_layer]),
    .fire        (ev_vfire),
    .vp_valid    (vp_valid),
    .vp_y        (vp_y),
    .vp_layer    (vp_layer),
    .vp_orient   (vp_orient),
    .vp_xext     (vp_xext)
  );

endmodule

// File: rtl/drc_scan_checker_sva.sv
module drc_scan_checker_sva
  import drc_pkg::*;
#(
  parameter int NL = 4,
  parameter int YW = 18,
  parameter int LW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pt_valid,
  input logic             pt_marker,
  input logic             pt_true,
  input logic             pt_true_end,
  input logic             pt_end,
  input logic             pt_virtual,
  input logic [YW-1:0]    pt_y,
  input logic [LW-1:0]    pt_layer,
  input logic [NL-1:0]    err_valid,
  input logic [YW-1:0]    err_y,
  input logic [LW-1:0]    err_layer,
  input logic [2*NL-1:0]  err_rule,
  input logic [YW*NL-1:0] err_yref,
  input logic             vp_valid,
  input logic [YW-1:0]    vp_y,
  input logic [LW-1:0]    vp_layer
);

  assert_marker_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pt_valid && pt_marker) |-> (err_valid == '0 && !vp_valid));

  assert_ignored_point_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pt_valid && !pt_marker && !pt_true && !pt_virtual) |-> (err_valid == '0 && !vp_valid));

  assert_record_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid != '0) |-> (err_y == $past(pt_y) && err_layer == $past(pt_layer)));

  assert_virtual_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vp_valid |-> $past(pt_valid && !pt_marker && !pt_virtual && pt_true_end && pt_end));

  assert_virtual_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vp_valid |-> (vp_y == $past(pt_y) && vp_layer == $past(pt_layer)));

  for (genvar k = 0; k < NL; k++) begin : g_lane
    assert_width_same_layer_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid[k] && err_rule[2*k +: 2] == 2'(RULE_WIDTH)) |-> (err_layer == LW'(k)));

    assert_space_same_layer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid[k] && err_rule[2*k +: 2] == 2'(RULE_SPACE)) |-> (err_layer == LW'(k)));

    assert_cross_other_layer_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid[k] && err_rule[2*k +: 2] == 2'(RULE_CROSS)) |-> (err_layer != LW'(k)));

    assert_positive_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid[k] |-> (err_y > err_yref[YW*k +: YW]));

    assert_rule_present_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid[k] |-> (err_rule[2*k +: 2] != 2'(RULE_NONE)));
  end

endmodule

bind drc_scan_checker drc_scan_checker_sva #(.NL(NL), .YW(YW), .LW(LW)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .pt_valid    (pt_valid),
  .pt_marker   (pt_marker),
  .pt_true     (pt_true),
  .pt_true_end (pt_true_end),
  .pt_end      (pt_end),
  .pt_virtual  (pt_virtual),
  .pt_y        (pt_y),
  .pt_layer    (pt_layer),
  .err_valid   (err_valid),
  .err_y       (err_y),
  .err_layer   (err_layer),
  .err_rule    (err_rule),
  .err_yref    (err_yref),
  .vp_valid    (vp_valid),
  .vp_y        (vp_y),
  .vp_layer    (vp_layer)
);

// File: tb/drc_scan_checker_test.sv
module drc_scan_checker_test;

  localparam int CLK_P = 10;
  localparam int NL = 4;
  localparam int YW = 18;
  localparam int TW = 6;
  localparam int LW = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [1:0]       cfg_kind;
  logic [LW-1:0]    cfg_la, cfg_lb;
  logic [TW-1:0]    cfg_val;
  logic             pt_valid, pt_marker, pt_orient, pt_start, pt_end;
  logic             pt_true, pt_true_end, pt_virtual, pt_right_in;
  logic [YW-1:0]    pt_y;
  logic [LW-1:0]    pt_layer;
  logic [NL-1:0]    err_valid;
  logic [YW-1:0]    err_x, err_y;
  logic [LW-1:0]    err_layer;
  logic [2*NL-1:0]  err_rule;
  logic [YW*NL-1:0] err_yref;
  logic             vp_valid, vp_orient;
  logic [YW-1:0]    vp_y;
  logic [LW-1:0]    vp_layer;
  logic [TW-1:0]    vp_xext;

  always #(CLK_P/2) clk = ~clk;

  drc_scan_checker #(.NL(NL), .YW(YW), .TW(TW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_la(cfg_la), .cfg_lb(cfg_lb), .cfg_val(cfg_val),
    .pt_valid(pt_valid), .pt_marker(pt_marker), .pt_y(pt_y), .pt_layer(pt_layer),
    .pt_orient(pt_orient), .pt_start(pt_start), .pt_end(pt_end), .pt_true(pt_true),
    .pt_true_end(pt_true_end), .pt_virtual(pt_virtual), .pt_right_in(pt_right_in),
    .err_valid(err_valid), .err_x(err_x), .err_y(err_y), .err_layer(err_layer),
    .err_rule(err_rule), .err_yref(err_yref),
    .vp_valid(vp_valid), .vp_y(vp_y), .vp_layer(vp_layer), .vp_orient(vp_orient),
    .vp_xext(vp_xext)
  );

  // Reference model state
  int m_valid [NL];
  int m_y     [NL];
  int m_o     [NL];
  int m_s     [NL];
  int t_w     [NL];
  int t_s     [NL];
  int t_x     [NL][NL];
  int m_x;

  // Expected outputs for the current cycle
  int e_ev;
  int e_rule [NL];
  int e_yref [NL];
  int e_x, e_y, e_layer;
  int e_vp, e_vy, e_vl, e_vo, e_vx;

  int n_chk  = 0;
  int n_fail = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "err_valid", int'(err_valid), e_ev);
    for (int k = 0; k < NL; k++) begin
      if (e_ev[k]) begin
        check(tag, $sformatf("rule lane %0d", k), int'(err_rule[2*k +: 2]), e_rule[k]);
        check(tag, $sformatf("yref lane %0d", k), int'(err_yref[YW*k +: YW]), e_yref[k]);
      end
    end
    if (e_ev != 0) begin
      check(tag, "err_x", int'(err_x), e_x);
      check(tag, "err_y", int'(err_y), e_y);
      check(tag, "err_layer", int'(err_layer), e_layer);
    end
    check(tag, "vp_valid", int'(vp_valid), e_vp);
    if (e_vp != 0) begin
      check(tag, "vp_y", int'(vp_y), e_vy);
      check(tag, "vp_layer", int'(vp_layer), e_vl);
      check(tag, "vp_orient", int'(vp_orient), e_vo);
      check(tag, "vp_xext", int'(vp_xext), e_vx);
    end
  endtask

  task automatic clear_expect();
    e_ev = 0;
    e_vp = 0;
    for (int k = 0; k < NL; k++) begin
      e_rule[k] = 0;
      e_yref[k] = 0;
    end
  endtask

  task automatic idle(input string tag);
    pt_valid = 1'b0;
    clear_expect();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic cfg(input int kind, input int la, input int lb, input int val);
    cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_la = LW'(la); cfg_lb = LW'(lb); cfg_val = TW'(val);
    pt_valid = 1'b0;
    clear_expect();
    @(negedge clk);
    cfg_we = 1'b0;
    compare("R11");
    if (kind == 0) t_w[la] = val;
    else if (kind == 1) t_s[la] = val;
    else begin
      t_x[la][lb] = val;
      t_x[lb][la] = val;
    end
  endtask

  // Drive one point, predict, then compare one clock later.
  task automatic point(input bit mk, input int y, input int ly, input bit o,
                       input bit st, input bit en, input bit tr, input bit te,
                       input bit vi, input bit ri, input string tag);
    bit take, tstart;
    pt_valid = 1'b1; pt_marker = mk; pt_y = YW'(y); pt_layer = LW'(ly);
    pt_orient = o; pt_start = st; pt_end = en; pt_true = tr; pt_true_end = te;
    pt_virtual = vi; pt_right_in = ri;
    clear_expect();
    take   = !mk && (tr || vi);
    tstart = take && !vi && st && te;
    if (take) begin
      for (int k = 0; k < NL; k++) begin
        int r, thr, d;
        r = 0; thr = 0;
        if (m_valid[k] != 0) begin
          if (k == ly) begin
            if (m_o[k] == 0 && o) begin r = 1; thr = t_w[k]; end
            else if (m_o[k] == 1 && !o) begin r = 2; thr = t_s[k]; end
          end else if (m_o[k] == 1 && !o) begin
            r = 3; thr = t_x[k][ly];
          end
        end
        d = y - m_y[k];
        if (r != 0 && d > 0 && d < thr && (tstart || m_s[k] != 0)) begin
          e_ev[k]   = 1'b1;
          e_rule[k] = r;
          e_yref[k] = m_y[k];
        end
      end
      e_x = m_x; e_y = y; e_layer = ly;
      if (!vi && te && en && ((!o && !ri) || (o && ri))) begin
        int mx;
        mx = t_w[ly];
        if (t_s[ly] > mx) mx = t_s[ly];
        for (int j = 0; j < NL; j++) if (j != ly && t_x[ly][j] > mx) mx = t_x[ly][j];
        e_vp = 1; e_vy = y; e_vl = ly; e_vo = int'(o); e_vx = mx;
      end
    end
    if (mk) begin
      m_x = y;
      for (int k = 0; k < NL; k++) m_valid[k] = 0;
    end else if (take && tr && !vi) begin
      m_valid[ly] = 1; m_y[ly] = y; m_o[ly] = int'(o); m_s[ly] = int'(st);
    end
    @(negedge clk);
    pt_valid = 1'b0;
    compare(tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_P * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_kind = '0; cfg_la = '0; cfg_lb = '0; cfg_val = '0;
    pt_valid = 1'b0; pt_marker = 1'b0; pt_y = '0; pt_layer = '0; pt_orient = 1'b0;
    pt_start = 1'b0; pt_end = 1'b0; pt_true = 1'b0; pt_true_end = 1'b0;
    pt_virtual = 1'b0; pt_right_in = 1'b0;
    m_x = 0;
    for (int k = 0; k < NL; k++) begin
      m_valid[k] = 0; m_y[k] = 0; m_o[k] = 0; m_s[k] = 0; t_w[k] = 0; t_s[k] = 0;
      for (int j = 0; j < NL; j++) t_x[k][j] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check("R12", "err_valid", int'(err_valid), 0);
    check("R12", "vp_valid", int'(vp_valid), 0);
    check("R12", "err_rule", int'(err_rule), 0);
    check("R12", "vp_xext", int'(vp_xext), 0);

    // R12: zero thresholds mean nothing fires
    point(1, 50, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    point(0, 10, 1, 0, 1, 0, 1, 1, 0, 0, "R12");
    point(0, 11, 1, 1, 1, 0, 1, 1, 0, 0, "R12");

    // R11: threshold loading
    cfg(0, 1, 0, 6);
    cfg(1, 1, 0, 8);
    cfg(0, 2, 0, 5);
    cfg(1, 2, 0, 4);
    cfg(2, 1, 2, 10);
    cfg(2, 3, 1, 3);

    // R1: marker starts a fresh scanline
    point(1, 100, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    point(0, 10, 1, 0, 1, 0, 1, 1, 0, 0, "R1");
    point(0, 14, 1, 1, 1, 0, 1, 1, 0, 0, "R3");
    point(0, 20, 1, 0, 1, 0, 1, 1, 0, 0, "R4");
    point(0, 23, 1, 1, 0, 1, 1, 1, 0, 1, "R8");
    idle("R10");
    point(0, 30, 2, 0, 1, 0, 1, 1, 0, 0, "R5");
    point(0, 31, 1, 0, 1, 0, 1, 1, 0, 0, "R6");
    point(0, 37, 1, 1, 1, 0, 1, 1, 0, 0, "R6");
    point(0, 40, 1, 0, 0, 0, 0, 0, 1, 0, "R7");
    point(0, 44, 1, 0, 0, 0, 1, 0, 0, 0, "R2");
    point(0, 46, 1, 1, 0, 0, 1, 0, 0, 0, "R7");
    point(0, 47, 1, 0, 1, 0, 0, 0, 0, 0, "R2");
    point(0, 50, 1, 0, 1, 0, 1, 1, 0, 0, "R2");
    point(0, 50, 1, 1, 1, 0, 1, 1, 0, 0, "R6");
    point(0, 52, 3, 0, 1, 0, 1, 1, 0, 0, "R5");
    point(0, 53, 3, 0, 0, 1, 1, 1, 0, 0, "R9");
    point(0, 54, 3, 0, 0, 1, 1, 1, 0, 1, "R8");
    point(0, 55, 3, 1, 0, 1, 1, 1, 0, 0, "R8");

    // R1: a second marker clears all layers
    point(1, 200, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    point(0, 60, 1, 0, 1, 0, 1, 1, 0, 0, "R1");
    point(0, 62, 1, 1, 1, 0, 1, 1, 0, 0, "R10");
    point(0, 63, 2, 0, 1, 0, 1, 1, 0, 0, "R5");
    point(0, 64, 2, 1, 1, 0, 1, 1, 0, 0, "R3");
    point(0, 66, 2, 0, 1, 0, 1, 1, 0, 0, "R10");
    point(0, 65, 1, 0, 1, 0, 1, 1, 0, 0, "R6");

    // R11: a new cross threshold affects the next point
    cfg(2, 2, 1, 1);
    point(0, 68, 1, 1, 1, 0, 1, 1, 0, 0, "R11");
    point(0, 69, 2, 0, 1, 0, 1, 1, 0, 0, "R11");
    point(0, 70, 0, 0, 1, 1, 1, 1, 0, 0, "R9");
    idle("R10");

    summary();
    $finish;
  end

endmodule